// File: doc/BRIEF.md
# Serial Monitor Command Interpreter

This block sits behind a serial byte receiver and in front of a serial byte transmitter. It decodes a small fixed set of single-byte opcodes for a debug and programming monitor. It collects each opcode's operand bytes and carries out the command. Commands can read a byte at an address, write a byte at an address, stream bytes from an implicit pointer, write a byte through that pointer, report a stack-pointer value taken from an input, or raise a one-cycle run request. Every byte received is echoed back on the transmit side before the interpreter accepts another one, so a host can confirm the link byte by byte.

Memory is reached over a simple synchronous bus. A request is one cycle wide and read data returns on the following cycle. A 16-bit pointer holds the address touched most recently. The incremental commands start from the address after it and advance it, so a host can stream through memory without resending addresses. A security input gates every command that touches memory. While it is low, those commands still echo their bytes but cause no bus traffic and no reply. Stack-pointer reporting and the run request still work.

Top module: `mon_cmd_engine`

## Requirements
- R1: Every byte accepted on the receive side is offered on the transmit side as an echo, unchanged. No further byte is accepted until that echo has been taken.
- R2: Opcode 0x4A followed by an address (high byte, then low byte) causes one bus read at that address. The byte read is sent back, and the pointer becomes that address.
- R3: Opcode 0x49 followed by an address (high, then low) and one data byte causes one bus write of that byte at that address. No reply byte is sent, and the pointer becomes that address.
- R4: Opcode 0x1A takes no operand. It reads pointer+1 and then pointer+2 and sends both bytes in that order. The pointer then advances by two.
- R5: Opcode 0x19 followed by one data byte writes it at pointer+1. No reply byte is sent, and the pointer advances by one.
- R6: Opcode 0x0C takes no operand. It sends the stack-pointer input high byte first and then the low byte, whatever the state of the security input.
- R7: Opcode 0x28 produces exactly one single-cycle run pulse and sends no reply byte, whatever the state of the security input.
- R8: Any other opcode is echoed and then discarded. The next byte received is treated as a new opcode.
- R9: While the security input is low, opcodes 0x4A, 0x49, 0x1A and 0x19 echo their bytes but make no bus access and send no reply, and they leave the pointer unchanged.
- R10: After reset the receiver is ready, nothing is offered for transmit, the bus is idle, no run pulse is active, and the pointer is 0x0000.
- R11: Pointer arithmetic wraps modulo 2^16, so the address after 0xFFFF is 0x0000.
- R12: While a transmit byte is offered and not taken, it stays offered with its value unchanged. Bus read data is taken on the cycle after the request.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| rx_valid | input | 1 | Received byte available |
| rx_data | input | 8 | Received byte |
| rx_ready | output | 1 | Interpreter accepts a byte |
| tx_valid | output | 1 | Byte offered for transmit |
| tx_data | output | 8 | Byte to transmit |
| tx_ready | input | 1 | Transmitter takes the byte |
| mem_req | output | 1 | Bus access this cycle |
| mem_we | output | 1 | Access is a write |
| mem_addr | output | 16 | Bus address |
| mem_wdata | output | 8 | Write data |
| mem_rdata | input | 8 | Read data, valid the cycle after a read request |
| sp_value | input | 16 | Stack-pointer value to report |
| unlocked | input | 1 | High when memory commands are permitted |
| run_pulse | output | 1 | One-cycle run request |

## Verification
The hardest state to reach is a pointer that was left behind by one command and is then used by a different command. This matters most when security was dropped in between or when the pointer sits at the top of the address space. The stimulus reaches it with chains of commands: an addressed access, then locked memory commands that must leave the pointer alone, then an incremental read whose bus addresses show where the pointer stood. A write at 0xFFFF followed by an incremental write and an incremental read drives the wrap. The transmitter is also stalled on a sparse pattern, so that echoes and replies sit offered for several cycles.

// File: rtl/mon_cmd_engine.sv
module mon_cmd_engine (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        rx_valid,
  input  logic [7:0]  rx_data,
  output logic        rx_ready,
  output logic        tx_valid,
  output logic [7:0]  tx_data,
  input  logic        tx_ready,
  output logic        mem_req,
  output logic        mem_we,
  output logic [15:0] mem_addr,
  output logic [7:0]  mem_wdata,
  input  logic [7:0]  mem_rdata,
  input  logic [15:0] sp_value,
  input  logic        unlocked,
  output logic        run_pulse
);
  localparam logic [7:0] OP_RD  = 8'h4A;
  localparam logic [7:0] OP_WR  = 8'h49;
  localparam logic [7:0] OP_IRD = 8'h1A;
  localparam logic [7:0] OP_IWR = 8'h19;
  localparam logic [7:0] OP_SP  = 8'h0C;
  localparam logic [7:0] OP_RUN = 8'h28;

  typedef enum logic [2:0] {S_RX, S_ECHO, S_EXEC, S_RDREQ, S_RDCAP, S_SEND, S_WR} st_t;

  st_t         st;
  logic [7:0]  cmd, txb, hold, wdat;
  logic [23:0] opr;
  logic [2:0]  nbytes;
  logic [15:0] addr, ptr;
  logic [1:0]  left;
  logic        more, run_q;

  function automatic logic known(input logic [7:0] op);
    return op == OP_RD || op == OP_WR || op == OP_IRD || op == OP_IWR ||
           op == OP_SP || op == OP_RUN;
  endfunction

  function automatic logic [2:0] need(input logic [7:0] op);
    case (op)
      OP_RD:   return 3'd2;
      OP_WR:   return 3'd3;
      OP_IWR:  return 3'd1;
      default: return 3'd0;
    endcase
  endfunction

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st     <= S_RX;
      cmd    <= '0;
      txb    <= '0;
      hold   <= '0;
      wdat   <= '0;
      opr    <= '0;
      nbytes <= '0;
      addr   <= '0;
      ptr    <= '0;
      left   <= '0;
      more   <= 1'b0;
      run_q  <= 1'b0;
    end else begin
      run_q <= (st == S_EXEC) && (cmd == OP_RUN);
      case (st)
        S_RX: if (rx_valid) begin
          if (nbytes == 3'd0) cmd <= rx_data;
          else                opr <= {opr[15:0], rx_data};
          nbytes <= nbytes + 3'd1;
          txb    <= rx_data;
          st     <= S_ECHO;
        end
        S_ECHO: if (tx_ready) begin
          if (!known(cmd)) begin
            nbytes <= '0;
            st     <= S_RX;
          end else if (nbytes == need(cmd) + 3'd1) begin
            st <= S_EXEC;
          end else begin
            st <= S_RX;
          end
        end
        S_EXEC: begin
          nbytes <= '0;
          st     <= S_RX;
          case (cmd)
            OP_RD: if (unlocked) begin
              addr <= opr[15:0];
              ptr  <= opr[15:0];
              left <= 2'd1;
              st   <= S_RDREQ;
            end
            OP_WR: if (unlocked) begin
              addr <= opr[23:8];
              ptr  <= opr[23:8];
              wdat <= opr[7:0];
              st   <= S_WR;
            end
            OP_IRD: if (unlocked) begin
              addr <= ptr + 16'd1;
              ptr  <= ptr + 16'd2;
              left <= 2'd2;
              st   <= S_RDREQ;
            end
            OP_IWR: if (unlocked) begin
              addr <= ptr + 16'd1;
              ptr  <= ptr + 16'd1;
              wdat <= opr[7:0];
              st   <= S_WR;
            end
            OP_SP: begin
              txb  <= sp_value[15:8];
              hold <= sp_value[7:0];
              more <= 1'b1;
              left <= 2'd0;
              st   <= S_SEND;
            end
            default: ;
          endcase
        end
        S_RDREQ: begin
          left <= left - 2'd1;
          st   <= S_RDCAP;
        end
        S_RDCAP: begin
          txb  <= mem_rdata;
          addr <= addr + 16'd1;
          more <= 1'b0;
          st   <= S_SEND;
        end
        S_SEND: if (tx_ready) begin
          if (more) begin
            txb  <= hold;
            more <= 1'b0;
          end else if (left != 2'd0) begin
            st <= S_RDREQ;
          end else begin
            st <= S_RX;
          end
        end
        S_WR: st <= S_RX;
        default: st <= S_RX;
      endcase
    end
  end

  assign rx_ready  = (st == S_RX);
  assign tx_valid  = (st == S_ECHO) || (st == S_SEND);
  assign tx_data   = txb;
  assign mem_req   = (st == S_RDREQ) || (st == S_WR);
  assign mem_we    = (st == S_WR);
  assign mem_addr  = addr;
  assign mem_wdata = wdat;
  assign run_pulse = run_q;

  // R1
  echo_byte_chk: assert property (@(posedge clk) disable iff (!rst_n)
    rx_valid && rx_ready |=> tx_valid && tx_data == $past(rx_data));

  // R1
  no_accept_while_tx_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !(rx_ready && tx_valid));

  // R12
  tx_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    tx_valid && !tx_ready |=> tx_valid && $stable(tx_data));

  // R7
  run_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
    run_pulse |=> !run_pulse);

  // R9
  locked_bus_chk: assert property (@(posedge clk) disable iff (!rst_n)
    mem_req |-> unlocked);

  // R12
  read_capture_chk: assert property (@(posedge clk) disable iff (!rst_n)
    mem_req && !mem_we |=> !mem_req && !tx_valid);
endmodule

// File: tb/sim_mon_cmd_engine.sv
module sim_mon_cmd_engine;
  localparam int CLK_NS = 10;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        rx_valid = 1'b0;
  logic [7:0]  rx_data = '0;
  logic        rx_ready;
  logic        tx_valid;
  logic [7:0]  tx_data;
  logic        tx_ready = 1'b1;
  logic        mem_req, mem_we;
  logic [15:0] mem_addr;
  logic [7:0]  mem_wdata;
  logic [7:0]  mem_rdata = '0;
  logic [15:0] sp_value = 16'hBEEF;
  logic        unlocked = 1'b1;
  logic        run_pulse;

  int checks = 0, fails = 0;
  int got_runs = 0, exp_runs = 0;
  int cyc = 0;
  logic stall = 1'b0;
  logic done = 1'b0;

  logic [7:0]  bmem    [0:255];
  logic [7:0]  ref_mem [0:255];
  logic [15:0] ref_ptr = 16'h0000;

  logic [7:0]  exp_tx[$];
  string       exp_tx_tag[$];
  logic [24:0] exp_bus[$];
  string       exp_bus_tag[$];

  logic        prev_hold = 1'b0;
  logic [7:0]  prev_byte = '0;

  always #(CLK_NS/2) clk = ~clk;

  mon_cmd_engine u0 (
    .clk(clk), .rst_n(rst_n),
    .rx_valid(rx_valid), .rx_data(rx_data), .rx_ready(rx_ready),
    .tx_valid(tx_valid), .tx_data(tx_data), .tx_ready(tx_ready),
    .mem_req(mem_req), .mem_we(mem_we), .mem_addr(mem_addr),
    .mem_wdata(mem_wdata), .mem_rdata(mem_rdata),
    .sp_value(sp_value), .unlocked(unlocked), .run_pulse(run_pulse)
  );

  always @(posedge clk) begin
    if (mem_req) begin
      if (mem_we) bmem[mem_addr[7:0]] <= mem_wdata;
      mem_rdata <= bmem[mem_addr[7:0]];
    end
  end

  always @(posedge clk) begin
    cyc <= cyc + 1;
    #1 tx_ready = stall ? (cyc % 3 == 2) : 1'b1;
  end

  task automatic check(input bit ok, input string tag, input string what,
                       input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s %s: actual 0x%0h expected 0x%0h", tag, what, act, exp);
    end
  endtask

  always @(negedge clk) begin
    if (rst_n) begin
      if (prev_hold)
        check(tx_valid && tx_data == prev_byte, "R12", "held tx byte",
              {tx_valid, tx_data}, {1'b1, prev_byte});
      prev_hold = tx_valid && !tx_ready;
      prev_byte = tx_data;
      if (tx_valid && tx_ready) begin
        if (exp_tx.size() == 0) begin
          check(1'b0, "R1", "unexpected tx byte", tx_data, 0);
        end else begin
          automatic logic [7:0] e = exp_tx.pop_front();
          automatic string t = exp_tx_tag.pop_front();
          check(tx_data == e, t, "tx byte", tx_data, e);
        end
      end
      if (mem_req) begin
        if (exp_bus.size() == 0) begin
          check(1'b0, "R9", "unexpected bus access", {mem_we, mem_addr}, 0);
        end else begin
          automatic logic [24:0] e = exp_bus.pop_front();
          automatic string t = exp_bus_tag.pop_front();
          automatic logic [24:0] a = {mem_we, mem_addr, mem_we ? mem_wdata : 8'h00};
          check(a == e, t, "bus access", a, e);
        end
      end
      if (run_pulse) got_runs++;
    end
  end

  task automatic ex_tx(input logic [7:0] b, input string t);
    exp_tx.push_back(b);
    exp_tx_tag.push_back(t);
  endtask

  task automatic ex_rd(input logic [15:0] a, input string t);
    exp_bus.push_back({1'b0, a, 8'h00});
    exp_bus_tag.push_back(t);
    ex_tx(ref_mem[a[7:0]], t);
  endtask

  task automatic ex_wr(input logic [15:0] a, input logic [7:0] d, input string t);
    exp_bus.push_back({1'b1, a, d});
    exp_bus_tag.push_back(t);
    ref_mem[a[7:0]] = d;
  endtask

  task automatic send(input logic [7:0] b);
    ex_tx(b, "R1");
    @(negedge clk);
    rx_valid = 1'b1;
    rx_data  = b;
    while (!rx_ready) @(negedge clk);
    @(negedge clk);
    rx_valid = 1'b0;
  endtask

  task automatic settle(input string t);
    for (int i = 0; i < 300; i++) begin
      @(negedge clk);
      if (exp_tx.size() == 0 && exp_bus.size() == 0 && rx_ready) break;
    end
    repeat (4) @(negedge clk);
    check(exp_tx.size() == 0 && exp_bus.size() == 0, t, "pending expectations",
          exp_tx.size() + exp_bus.size(), 0);
  endtask

  task automatic do_read(input logic [15:0] a, input string t);
    send(8'h4A); send(a[15:8]); send(a[7:0]);
    if (unlocked) begin ex_rd(a, t); ref_ptr = a; end
    settle(t);
  endtask

  task automatic do_write(input logic [15:0] a, input logic [7:0] d, input string t);
    send(8'h49); send(a[15:8]); send(a[7:0]);
    if (unlocked) begin ex_wr(a, d, t); ref_ptr = a; end
    send(d);
    settle(t);
  endtask

  task automatic do_iread(input string t);
    send(8'h1A);
    if (unlocked) begin
      ex_rd(ref_ptr + 16'd1, t);
      ex_rd(ref_ptr + 16'd2, t);
      ref_ptr = ref_ptr + 16'd2;
    end
    settle(t);
  endtask

  task automatic do_iwrite(input logic [7:0] d, input string t);
    send(8'h19);
    if (unlocked) begin
      ex_wr(ref_ptr + 16'd1, d, t);
      ref_ptr = ref_ptr + 16'd1;
    end
    send(d);
    settle(t);
  endtask

  task automatic do_sp(input string t);
    send(8'h0C);
    ex_tx(sp_value[15:8], t);
    ex_tx(sp_value[7:0], t);
    settle(t);
  endtask

  task automatic do_run(input string t);
    send(8'h28);
    exp_runs++;
    settle(t);
    check(got_runs == exp_runs, t, "run pulse cycles", got_runs, exp_runs);
  endtask

  initial begin
    #(CLK_NS * 100000);
    if (!done) begin
      fails++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
      $finish;
    end
  end

  initial begin
    for (int i = 0; i < 256; i++) begin
      bmem[i]    = 8'(i * 7 + 3);
      ref_mem[i] = 8'(i * 7 + 3);
    end
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R10: idle outputs after reset
    check(rx_ready == 1'b1, "R10", "rx_ready", rx_ready, 1);
    check(tx_valid == 1'b0, "R10", "tx_valid", tx_valid, 0);
    check(mem_req == 1'b0, "R10", "mem_req", mem_req, 0);
    check(run_pulse == 1'b0, "R10", "run_pulse", run_pulse, 0);

    do_iread("R10");
    do_read(16'h0040, "R2");
    do_iread("R4");
    do_write(16'h1234, 8'hA5, "R3");
    do_iwrite(8'h5C, "R5");
    do_read(16'h1235, "R5");
    do_sp("R6");
    do_run("R7");

    send(8'h77);
    settle("R8");
    send(8'h00);
    settle("R8");
    do_sp("R8");

    unlocked = 1'b0;
    do_read(16'h0010, "R9");
    do_write(16'h0011, 8'h99, "R9");
    do_iread("R9");
    do_iwrite(8'h66, "R9");
    sp_value = 16'h1357;
    do_sp("R6");
    do_run("R7");
    unlocked = 1'b1;
    do_iread("R9");

    do_write(16'hFFFF, 8'h11, "R11");
    do_iwrite(8'h22, "R11");
    do_iread("R11");
    do_read(16'hFFFE, "R11");
    do_iread("R11");

    stall = 1'b1;
    sp_value = 16'hC0DE;
    do_sp("R12");
    do_read(16'h0005, "R12");
    do_iread("R12");
    send(8'h5A);
    settle("R8");
    do_run("R7");
    stall = 1'b0;

    done = 1'b1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
    $finish;
  end
endmodule